// File: doc/BRIEF.md
# Secure power-control register bank

This block is the register file of a power controller on a simple request/ready bus. It holds two control words for the application processor side, a supply-side control word, a backup-domain control word, a control word for the secondary controller, a read-only detector status word, and a wakeup group. The wakeup group has pin configuration (polarity, pull selection, clear strobes), a latched flag word and two enable words, one for each processor. Identification words at the top of the space return fixed parameter values. Regulator and detector hardware is outside the block; detector outputs arrive on input ports.

Every register has a write access policy. With the global security enable high, a non-secure write to a guarded register is dropped and answered with an error. In the wakeup configuration word, a non-secure write is filtered pin by pin, according to the secure enable word, and raises no error. The backup-domain word takes writes only while a protect-release bit is set. Writes complete after a fixed number of wait states; reads complete at once. The registers are split across four reset inputs: system, application, power-on and backup domain.

A request is a one-cycle `req_i` pulse, sampled while the block is idle. The requester then waits for the single-cycle `ready_o` pulse. `rdata_o` and `err_o` are valid only with that pulse.

Top module: `pwr_regbank`

## Requirements
- R1: While `sec_en_i` is high, a write with `secure_i` low to the main control (byte offset 0x00), backup control (0x08), supply control (0x0C), application-processor control (0x10) or secure wake-enable word (0x28) leaves the register unchanged and returns `err_o`=1. With `sec_en_i` low, or `secure_i` high, the write is applied and `err_o`=0.
- R2: Reads are granted whatever the values of `secure_i` and `sec_en_i`. Unmapped or unaligned offsets read 0. Writes to read-only offsets have no effect. Offset 0x04 reads `adet_i` at bit 16 and `vdet_i` at bit 4. Offsets 0x3F4, 0x3F8 and 0x3FC return the parameters VER_VAL, ID_VAL and SID_VAL.
- R3: The backup control word accepts a write only while bit 8 of the main control word is 1. A write that this rule blocks raises no error.
- R4: A read gives `ready_o` in the cycle after the request. A write gives `ready_o` WS cycles later than a read would (WS=6 by default, so 7 cycles after the request).
- R5: Wake configuration (0x20) places clear strobes at [5:0], polarity at [13:8] and a 2-bit pull field for pin n at [17+2n:16+2n]. For a non-secure write while `sec_en_i` is high, the fields of pin n are kept unchanged when bit n of 0x28 is set. The other pins are written, and no error is raised.
- R6: The secondary-controller control word (0x14) and its wake-enable word (0x2C) accept non-secure writes whatever the value of `sec_en_i`, without error.
- R7: Flag n (bit n of 0x24) is set by a rising edge on `wkup_i[n]` while bit n of 0x28 or 0x2C is set. It stays set until it is cleared through its strobe bit in 0x20. The strobe bits read back as 0.
- R8: A write that clears a flag which is set completes one cycle later than a plain write (8 cycles after the request), and the flag is already 0 when `ready_o` rises. A strobe for a flag that is already clear adds no cycle.
- R9: `rst_ni` clears 0x00, 0x10 and 0x14. `app_rst_ni` clears the wakeup group. `por_rst_ni` clears 0x0C only. `bkp_rst_ni` clears 0x08 only. No reset touches a register outside its own group.
- R10: Only implemented bits are stored. The writable masks are 0x000701F7 (0x00), 0x00000013 (0x08), 0x513E1F00 (0x0C), 0x00008009 (0x10), 0x00008001 (0x14) and 0x3F (wake enables). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| app_rst_ni | input | 1 | Application reset, active low |
| por_rst_ni | input | 1 | Power-on reset, active low |
| bkp_rst_ni | input | 1 | Backup-domain reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Requester is secure |
| sec_en_i | input | 1 | Global security enable |
| wkup_i | input | NPIN | Wakeup event lines |
| vdet_i | input | 1 | Supply detector output |
| adet_i | input | 1 | Analog supply detector output |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | Transfer complete, one-cycle pulse |
| err_o | output | 1 | Access error, valid with ready_o |

## Verification
Counted from the clock edge that samples `req_i`, a read ends with `ready_o` one cycle later, a plain write WS+1 cycles later, and a write that clears a set flag WS+2 cycles later. The bench counts falling edges from the request until it sees `ready_o`, compares that count with these figures, and samples `rdata_o` and `err_o` in the same half-cycle. Register contents are always read back through a separate secure read that starts after the write has finished. Wakeup pulses and reset pulses each span one rising edge, and their effects are read back only after that edge.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [3:0] {
    R_CTRL1, R_STAT1, R_CTRL2, R_CTRL3, R_CPUC, R_MCUC,
    R_WKC, R_WKF, R_WKEN, R_MWKEN, R_VER, R_ID, R_SID, R_NONE
  } reg_e;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CLR, S_RESP} st_e;

  localparam logic [31:0] CTRL1_MASK = 32'h0007_01F7;
  localparam logic [31:0] CTRL2_MASK = 32'h0000_0013;
  localparam logic [31:0] CTRL3_MASK = 32'h513E_1F00;
  localparam logic [31:0] CPUC_MASK  = 32'h0000_8009;
  localparam logic [31:0] MCUC_MASK  = 32'h0000_8001;
  localparam int          DBP_BIT    = 8;
  localparam int          POL_LSB    = 8;
  localparam int          PULL_LSB   = 16;

  function automatic reg_e decode(input logic [31:0] idx);
    case (idx)
      32'd0:   return R_CTRL1;
      32'd1:   return R_STAT1;
      32'd2:   return R_CTRL2;
      32'd3:   return R_CTRL3;
      32'd4:   return R_CPUC;
      32'd5:   return R_MCUC;
      32'd8:   return R_WKC;
      32'd9:   return R_WKF;
      32'd10:  return R_WKEN;
      32'd11:  return R_MWKEN;
      32'd253: return R_VER;
      32'd254: return R_ID;
      32'd255: return R_SID;
      default: return R_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pwr_bus_fsm.sv
module pwr_bus_fsm #(
  parameter int AW = 10,
  parameter int WS = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          secure_i,
  input  logic          deny_i,
  input  logic          need_clr_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic          clr_phase_o,
  output logic          ready_o,
  output logic          err_o,
  output logic          lat_we_o,
  output logic [AW-1:0] lat_addr_o,
  output logic [31:0]   lat_wdata_o,
  output logic          lat_sec_o
);
  import pwr_pkg::*;
  localparam int CW = $clog2(WS + 1);

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;

  assign commit_o    = (st_q == S_WAIT) && (cnt_q == CW'(WS - 1));
  assign clr_phase_o = (st_q == S_CLR);
  assign ready_o     = (st_q == S_RESP);
  assign busy_o      = (st_q != S_IDLE);
  assign err_o       = ready_o && err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      err_q       <= 1'b0;
      lat_we_o    <= 1'b0;
      lat_addr_o  <= '0;
      lat_wdata_o <= '0;
      lat_sec_o   <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          lat_we_o    <= we_i;
          lat_addr_o  <= addr_i;
          lat_wdata_o <= wdata_i;
          lat_sec_o   <= secure_i;
          err_q       <= 1'b0;
          cnt_q       <= '0;
          st_q        <= we_i ? S_WAIT : S_RESP;
        end
        S_WAIT: if (commit_o) begin
          err_q <= deny_i;
          st_q  <= need_clr_i ? S_CLR : S_RESP;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        // hold completion until the targeted flags read low
        S_CLR:  if (!need_clr_i) st_q <= S_RESP;
        S_RESP: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_access.sv
module pwr_access #(
  parameter int NPIN = 6
) (
  input  pwr_pkg::reg_e   reg_i,
  input  logic            secure_i,
  input  logic            sec_en_i,
  input  logic            dbp_i,
  input  logic [NPIN-1:0] wken_i,
  output logic            deny_o,
  output logic            wr_ok_o,
  output logic [NPIN-1:0] pin_ok_o
);
  import pwr_pkg::*;
  logic guarded, ns;

  assign ns = sec_en_i && !secure_i;

  always_comb begin
    guarded = 1'b0;
    case (reg_i)
      R_CTRL1, R_CTRL2, R_CTRL3, R_CPUC, R_WKEN: guarded = 1'b1;
      default: guarded = 1'b0;
    endcase
  end

  assign deny_o = guarded && ns;

  always_comb begin
    case (reg_i)
      R_CTRL1, R_CTRL3, R_CPUC, R_MCUC, R_WKC, R_WKEN, R_MWKEN: wr_ok_o = !deny_o;
      R_CTRL2: wr_ok_o = !deny_o && dbp_i;  // silent protect
      default: wr_ok_o = 1'b0;
    endcase
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    assign pin_ok_o[n] = !(ns && wken_i[n]);
  end
endmodule

// File: rtl/pwr_wake.sv
module pwr_wake #(
  parameter int NPIN = 6
) (
  input  logic              clk_i,
  input  logic              app_rst_ni,
  input  logic              wr_ctl_i,
  input  logic [NPIN-1:0]   pin_ok_i,
  input  logic [NPIN-1:0]   pol_i,
  input  logic [2*NPIN-1:0] pull_i,
  input  logic              wr_en_i,
  input  logic              wr_men_i,
  input  logic [NPIN-1:0]   en_val_i,
  input  logic [NPIN-1:0]   clr_i,
  input  logic [NPIN-1:0]   evt_i,
  output logic [31:0]       ctl_rd_o,
  output logic [NPIN-1:0]   flag_o,
  output logic [NPIN-1:0]   en_o,
  output logic [NPIN-1:0]   men_o
);
  import pwr_pkg::*;
  logic [NPIN-1:0]   pol_v;
  logic [2*NPIN-1:0] pull_v;

  always_ff @(posedge clk_i or negedge app_rst_ni) begin
    if (!app_rst_ni) begin
      en_o  <= '0;
      men_o <= '0;
    end else begin
      if (wr_en_i)  en_o  <= en_val_i;
      if (wr_men_i) men_o <= en_val_i;
    end
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic       pol_r, flag_r, evt_r;
    logic [1:0] pull_r;
    always_ff @(posedge clk_i or negedge app_rst_ni) begin
      if (!app_rst_ni) begin
        pol_r  <= 1'b0;
        pull_r <= 2'b00;
        flag_r <= 1'b0;
        evt_r  <= 1'b0;
      end else begin
        evt_r <= evt_i[n];
        if (wr_ctl_i && pin_ok_i[n]) begin
          pol_r  <= pol_i[n];
          pull_r <= pull_i[2*n +: 2];
        end
        // clear dominates a coincident event
        flag_r <= (flag_r | (evt_i[n] & ~evt_r & (en_o[n] | men_o[n]))) & ~clr_i[n];
      end
    end
    assign pol_v[n]        = pol_r;
    assign pull_v[2*n +: 2] = pull_r;
    assign flag_o[n]       = flag_r;
  end

  always_comb begin
    ctl_rd_o = '0;
    ctl_rd_o[POL_LSB +: NPIN]    = pol_v;
    ctl_rd_o[PULL_LSB +: 2*NPIN] = pull_v;
  end
endmodule

// File: rtl/pwr_regbank.sv
module pwr_regbank #(
  parameter int          AW      = 10,
  parameter int          WS      = 6,
  parameter int          NPIN    = 6,
  parameter logic [31:0] VER_VAL = 32'h0000_0021,
  parameter logic [31:0] ID_VAL  = 32'h0017_0031,
  parameter logic [31:0] SID_VAL = 32'hA3C5_DD01
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            app_rst_ni,
  input  logic            por_rst_ni,
  input  logic            bkp_rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            secure_i,
  input  logic            sec_en_i,
  input  logic [NPIN-1:0] wkup_i,
  input  logic            vdet_i,
  input  logic            adet_i,
  output logic [31:0]     rdata_o,
  output logic            ready_o,
  output logic            err_o
);
  import pwr_pkg::*;

  logic            busy, commit, clr_phase, deny, wr_ok, need_clr, lat_we, lat_sec, fire;
  logic [AW-1:0]   lat_addr;
  logic [31:0]     lat_wdata, wkc_rd, rd_word;
  logic [NPIN-1:0] pin_ok, eff_clr, clr_apply, wk_flag, wk_en, wk_men;
  logic [31:0]     ctrl1_q, ctrl2_q, ctrl3_q, cpuc_q, mcuc_q;
  reg_e            lat_reg;
  logic            dbp;

  pwr_bus_fsm #(.AW(AW), .WS(WS)) u_fsm (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .secure_i,
    .deny_i(deny), .need_clr_i(need_clr), .busy_o(busy), .commit_o(commit),
    .clr_phase_o(clr_phase), .ready_o, .err_o, .lat_we_o(lat_we),
    .lat_addr_o(lat_addr), .lat_wdata_o(lat_wdata), .lat_sec_o(lat_sec)
  );

  assign lat_reg = (lat_addr[1:0] != 2'b00) ? R_NONE : decode(32'(lat_addr[AW-1:2]));
  assign dbp     = ctrl1_q[DBP_BIT];

  pwr_access #(.NPIN(NPIN)) u_acc (
    .reg_i(lat_reg), .secure_i(lat_sec), .sec_en_i, .dbp_i(dbp), .wken_i(wk_en),
    .deny_o(deny), .wr_ok_o(wr_ok), .pin_ok_o(pin_ok)
  );

  assign fire      = commit && lat_we && wr_ok;
  assign eff_clr   = (lat_we && lat_reg == R_WKC) ? (lat_wdata[NPIN-1:0] & pin_ok) : '0;
  assign need_clr  = |(eff_clr & wk_flag);
  assign clr_apply = (commit || clr_phase) ? eff_clr : '0;

  pwr_wake #(.NPIN(NPIN)) u_wake (
    .clk_i, .app_rst_ni,
    .wr_ctl_i(fire && lat_reg == R_WKC), .pin_ok_i(pin_ok),
    .pol_i(lat_wdata[POL_LSB +: NPIN]), .pull_i(lat_wdata[PULL_LSB +: 2*NPIN]),
    .wr_en_i(fire && lat_reg == R_WKEN), .wr_men_i(fire && lat_reg == R_MWKEN),
    .en_val_i(lat_wdata[NPIN-1:0]), .clr_i(clr_apply), .evt_i(wkup_i),
    .ctl_rd_o(wkc_rd), .flag_o(wk_flag), .en_o(wk_en), .men_o(wk_men)
  );

  // system-reset group
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl1_q <= '0;
      cpuc_q  <= '0;
      mcuc_q  <= '0;
    end else if (fire) begin
      if (lat_reg == R_CTRL1) ctrl1_q <= lat_wdata & CTRL1_MASK;
      if (lat_reg == R_CPUC)  cpuc_q  <= lat_wdata & CPUC_MASK;
      if (lat_reg == R_MCUC)  mcuc_q  <= lat_wdata & MCUC_MASK;
    end
  end

  // power-on group
  always_ff @(posedge clk_i or negedge por_rst_ni) begin
    if (!por_rst_ni)                   ctrl3_q <= '0;
    else if (fire && lat_reg == R_CTRL3) ctrl3_q <= lat_wdata & CTRL3_MASK;
  end

  // backup-domain group
  always_ff @(posedge clk_i or negedge bkp_rst_ni) begin
    if (!bkp_rst_ni)                   ctrl2_q <= '0;
    else if (fire && lat_reg == R_CTRL2) ctrl2_q <= lat_wdata & CTRL2_MASK;
  end

  always_comb begin
    case (lat_reg)
      R_CTRL1: rd_word = ctrl1_q;
      R_STAT1: rd_word = {15'd0, adet_i, 11'd0, vdet_i, 4'd0};
      R_CTRL2: rd_word = ctrl2_q;
      R_CTRL3: rd_word = ctrl3_q;
      R_CPUC:  rd_word = cpuc_q;
      R_MCUC:  rd_word = mcuc_q;
      R_WKC:   rd_word = wkc_rd;
      R_WKF:   rd_word = 32'(wk_flag);
      R_WKEN:  rd_word = 32'(wk_en);
      R_MWKEN: rd_word = 32'(wk_men);
      R_VER:   rd_word = VER_VAL;
      R_ID:    rd_word = ID_VAL;
      R_SID:   rd_word = SID_VAL;
      default: rd_word = '0;
    endcase
  end

  assign rdata_o = (ready_o && !lat_we) ? rd_word : '0;
endmodule

// File: rtl/pwr_regbank_chk.sv
module pwr_regbank_chk #(
  parameter int WS   = 6,
  parameter int NPIN = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            app_rst_ni,
  input logic            bkp_rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic            busy,
  input logic            ready_o,
  input logic            err_o,
  input logic            dbp,
  input logic [31:0]     ctrl2_q,
  input logic [NPIN-1:0] wk_flag,
  input logic [NPIN-1:0] wk_en,
  input logic [NPIN-1:0] wk_men,
  input logic            need_clr
);
  localparam int KW = $clog2(WS + 2) + 1;
  logic          wr_q;
  logic [KW-1:0] k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
      k_q  <= '0;
    end else if (req_i && !busy) begin
      wr_q <= we_i;
      k_q  <= '0;
    end else if (busy && k_q != '1) begin
      k_q <= k_q + 1'b1;
    end
  end

  p_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_q) |-> (k_q >= KW'(WS)));

  p_read_fast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy && !we_i) |=> ready_o);

  p_err_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> wr_q);

  p_protect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !bkp_rst_ni)
    !$past(dbp) |-> $stable(ctrl2_q));

  p_flag_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !app_rst_ni)
    (wk_flag & ~$past(wk_flag) & ~($past(wk_en) | $past(wk_men))) == '0);

  p_clr_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !need_clr);
endmodule

bind pwr_regbank pwr_regbank_chk #(.WS(WS), .NPIN(NPIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .app_rst_ni(app_rst_ni), .bkp_rst_ni(bkp_rst_ni),
  .req_i(req_i), .we_i(we_i), .busy(busy), .ready_o(ready_o), .err_o(err_o),
  .dbp(dbp), .ctrl2_q(ctrl2_q), .wk_flag(wk_flag), .wk_en(wk_en), .wk_men(wk_men),
  .need_clr(need_clr)
);

// File: tb/pwr_regbank_test.sv
module pwr_regbank_test;
  localparam int          AW   = 10;
  localparam int          NPIN = 6;
  localparam logic [31:0] VERV = 32'h0000_0021;
  localparam logic [31:0] IDV  = 32'h0017_0031;
  localparam logic [31:0] SIDV = 32'hA3C5_DD01;

  typedef struct packed {
    logic        we;
    logic        sec;
    logic        en;
    logic [9:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,10'h000,32'hFFFF_FFFF,32'h0007_01F7,1'b0,4'd10},
    '{1'b1,1'b0,1'b1,10'h000,32'h0000_0000,32'h0007_01F7,1'b1,4'd1},
    '{1'b1,1'b0,1'b0,10'h000,32'h0000_0011,32'h0000_0011,1'b0,4'd1},
    '{1'b1,1'b1,1'b1,10'h008,32'h0000_0013,32'h0000_0000,1'b0,4'd3},
    '{1'b1,1'b1,1'b1,10'h000,32'h0000_0100,32'h0000_0100,1'b0,4'd3},
    '{1'b1,1'b1,1'b1,10'h008,32'h0000_00FF,32'h0000_0013,1'b0,4'd3},
    '{1'b1,1'b0,1'b1,10'h008,32'h0000_0000,32'h0000_0013,1'b1,4'd1},
    '{1'b1,1'b0,1'b1,10'h00C,32'hFFFF_FFFF,32'h0000_0000,1'b1,4'd1},
    '{1'b1,1'b1,1'b1,10'h00C,32'hFFFF_FFFF,32'h513E_1F00,1'b0,4'd10},
    '{1'b1,1'b0,1'b1,10'h014,32'h0000_FFFF,32'h0000_8001,1'b0,4'd6},
    '{1'b1,1'b0,1'b1,10'h010,32'h0000_FFFF,32'h0000_0000,1'b1,4'd1},
    '{1'b1,1'b1,1'b1,10'h010,32'h0000_FFFF,32'h0000_8009,1'b0,4'd10},
    '{1'b1,1'b0,1'b1,10'h028,32'h0000_003F,32'h0000_0000,1'b1,4'd1},
    '{1'b1,1'b1,1'b1,10'h028,32'h0000_0005,32'h0000_0005,1'b0,4'd1},
    '{1'b1,1'b1,1'b1,10'h020,32'h0FFF_3F3F,32'h0FFF_3F00,1'b0,4'd5},
    '{1'b1,1'b0,1'b1,10'h020,32'h0000_0000,32'h0033_0500,1'b0,4'd5},
    '{1'b1,1'b0,1'b1,10'h02C,32'hFFFF_FFFF,32'h0000_003F,1'b0,4'd6},
    '{1'b1,1'b1,1'b1,10'h004,32'hFFFF_FFFF,32'h0000_0000,1'b0,4'd2},
    '{1'b1,1'b1,1'b1,10'h024,32'h0000_003F,32'h0000_0000,1'b0,4'd2},
    '{1'b0,1'b0,1'b1,10'h3F4,32'h0,VERV,1'b0,4'd2},
    '{1'b0,1'b0,1'b1,10'h3F8,32'h0,IDV,1'b0,4'd2},
    '{1'b0,1'b0,1'b0,10'h3FC,32'h0,SIDV,1'b0,4'd2},
    '{1'b0,1'b1,1'b1,10'h100,32'h0,32'h0,1'b0,4'd2},
    '{1'b0,1'b0,1'b1,10'h001,32'h0,32'h0,1'b0,4'd2}
  };

  logic clk = 0, rst_n = 0, app_rst_n = 0, por_rst_n = 0, bkp_rst_n = 0;
  logic req = 0, we = 0, sec = 0, sec_en = 0, vdet = 0, adet = 0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0, rdata;
  logic [NPIN-1:0] wkup = '0;
  logic            ready, err;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_regbank #(.AW(AW), .NPIN(NPIN), .VER_VAL(VERV), .ID_VAL(IDV), .SID_VAL(SIDV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .app_rst_ni(app_rst_n), .por_rst_ni(por_rst_n),
    .bkp_rst_ni(bkp_rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .secure_i(sec), .sec_en_i(sec_en), .wkup_i(wkup), .vdet_i(vdet), .adet_i(adet),
    .rdata_o(rdata), .ready_o(ready), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic s, input logic [AW-1:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic e, output int cyc);
    @(negedge clk);
    req = 1; we = w; sec = s; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    cyc = 1;
    while (!ready && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    rd = rdata; e = err;
  endtask

  task automatic rdreg(input logic [AW-1:0] a, output logic [31:0] rd);
    logic e; int c;
    bus(1'b0, 1'b1, a, 32'h0, rd, e, c);
  endtask

  task automatic wrreg(input logic s, input logic [AW-1:0] a, input logic [31:0] d,
                       output logic e, output int c);
    logic [31:0] rd;
    bus(1'b1, s, a, d, rd, e, c);
  endtask

  task automatic pulse_evt(input int n);
    @(negedge clk); wkup[n] = 1'b1;
    @(negedge clk); wkup[n] = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic e;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1; app_rst_n = 1; por_rst_n = 1; bkp_rst_n = 1;
    @(negedge clk);
    chk("R9 reset ready", {31'd0, ready}, 32'd0);
    rdreg(10'h000, rd); chk("R9 reset ctrl1", rd, 32'h0);
    rdreg(10'h008, rd); chk("R9 reset ctrl2", rd, 32'h0);
    rdreg(10'h00C, rd); chk("R9 reset ctrl3", rd, 32'h0);
    rdreg(10'h020, rd); chk("R9 reset wkc", rd, 32'h0);
    bus(1'b0, 1'b0, 10'h000, 32'h0, rd, e, c);
    chk("R4 read cycles", 32'(c), 32'd1);

    // vector walk: R1 R2 R3 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      sec_en = VECS[i].en;
      bus(VECS[i].we, VECS[i].sec, VECS[i].addr, VECS[i].wd, rd, e, c);
      chk($sformatf("R%0d vec%0d err", VECS[i].req, i), {31'd0, e}, {31'd0, VECS[i].err});
      if (VECS[i].we) begin
        chk($sformatf("R4 vec%0d write cycles", i), 32'(c), 32'd7);
        rdreg(VECS[i].addr, rd);
      end
      chk($sformatf("R%0d vec%0d data", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R2: detector status
    vdet = 1; adet = 1;
    rdreg(10'h004, rd); chk("R2 status word", rd, 32'h0001_0010);
    vdet = 0; adet = 0;

    // R7: event without enable, then with each enable word
    sec_en = 1;
    wrreg(1'b1, 10'h02C, 32'h0, e, c);
    pulse_evt(1);
    rdreg(10'h024, rd); chk("R7 no enable no flag", rd, 32'h0);
    pulse_evt(0);
    rdreg(10'h024, rd); chk("R7 flag via secure enable", rd, 32'h1);
    wrreg(1'b0, 10'h02C, 32'h2, e, c);
    pulse_evt(1);
    rdreg(10'h024, rd); chk("R7 flag via second enable", rd, 32'h3);

    // R5: non-secure clear of pin guarded by secure enable is dropped
    wrreg(1'b0, 10'h020, 32'h0000_0001, e, c);
    rdreg(10'h024, rd); chk("R5 guarded clear dropped", rd, 32'h3);
    chk("R5 no error", {31'd0, e}, 32'd0);

    // R8: clearing a set flag takes one more cycle
    wrreg(1'b1, 10'h020, 32'h0000_0001, e, c);
    chk("R8 clear cycles", 32'(c), 32'd8);
    rdreg(10'h024, rd); chk("R8 flag low", rd, 32'h2);
    wrreg(1'b1, 10'h020, 32'h0000_0001, e, c);
    chk("R8 clear of low flag cycles", 32'(c), 32'd7);
    wrreg(1'b0, 10'h020, 32'h0000_0002, e, c);
    rdreg(10'h024, rd); chk("R5 unguarded ns clear", rd, 32'h0);
    rdreg(10'h020, rd); chk("R7 strobes read zero", rd, 32'h0);

    // R9: reset groups
    wrreg(1'b1, 10'h020, 32'h0000_0100, e, c);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rdreg(10'h000, rd); chk("R9 sys rst ctrl1", rd, 32'h0);
    rdreg(10'h014, rd); chk("R9 sys rst mcu ctrl", rd, 32'h0);
    rdreg(10'h008, rd); chk("R9 sys rst keeps ctrl2", rd, 32'h13);
    rdreg(10'h00C, rd); chk("R9 sys rst keeps ctrl3", rd, 32'h513E_1F00);
    rdreg(10'h020, rd); chk("R9 sys rst keeps wkc", rd, 32'h100);
    @(negedge clk); app_rst_n = 0; @(negedge clk); app_rst_n = 1;
    rdreg(10'h020, rd); chk("R9 app rst wkc", rd, 32'h0);
    rdreg(10'h028, rd); chk("R9 app rst wken", rd, 32'h0);
    rdreg(10'h00C, rd); chk("R9 app rst keeps ctrl3", rd, 32'h513E_1F00);
    @(negedge clk); por_rst_n = 0; @(negedge clk); por_rst_n = 1;
    rdreg(10'h00C, rd); chk("R9 por ctrl3", rd, 32'h0);
    rdreg(10'h008, rd); chk("R9 por keeps ctrl2", rd, 32'h13);
    @(negedge clk); bkp_rst_n = 0; @(negedge clk); bkp_rst_n = 1;
    rdreg(10'h008, rd); chk("R9 bkp ctrl2", rd, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule